// File: doc/BRIEF.md
# Prescaled Dual Down-Counter Timer

This block provides two independent timers. Each is an 8-bit down counter stepped by a 6-bit down-counting prescaler. Software loads an initial count and a prescale value into holding registers. A load pulse copies both into the live counters and starts the timer. The live count can be read at any time. When a count runs out, the timer raises a one-cycle interrupt request and flips its square-wave output. It then either stops (single pass) or reloads and carries on (modulo-N).

Timer 0 steps on one of two sources. The first is the internal time base, the system clock divided by four. The second is an external pin, which can act as a count clock, a gate (count the time base only while the pin is high) or a trigger (a rising edge starts a run). Timer 1 steps either on the time base or on timer 0's end-of-count, which chains the two into one long counter.

Top module: `prescaled_timer_pair`

## Requirements
- R1: After reset, both counts read 0, `irq` and `tout` are 0, and neither timer counts until it is loaded.
- R2: With the internal source in modulo mode, end-of-count pulses repeat every 4·P·N clock cycles. P is the prescale value, with 0 meaning 64. N is the initial count, with 0 meaning 256.
- R3: In single-pass mode a timer gives exactly one end-of-count pulse. It then holds a count of 0 until the next load.
- R4: A load pulse on `load[i]` makes `count_i` equal the held initial value on the next cycle. Writing the holding register through `init_we[i]` alone does not change the live count.
- R5: Each end-of-count drives `irq[i]` high for exactly one cycle and inverts `tout[i]` in that same cycle. `tout[i]` changes at no other time.
- R6: When `t0_ext_src`=1 and `ext_fn`=2'b00 (clock), each rising edge of `ext_in` is one prescaler step of timer 0.
- R7: When `t0_ext_src`=1 and `ext_fn`=2'b01 (gate), timer 0 steps on the time base while `ext_in` is high. While `ext_in` is low, its count is frozen.
- R8: When `t0_ext_src`=1 and `ext_fn`=2'b10 (trigger), timer 0 waits after a load until a rising edge of `ext_in`, then counts the time base. Edges that arrive during a run are ignored. In modulo mode the timer reloads at end of count and waits for a new edge.
- R9: When `t1_cascade`=1, timer 1 takes one prescaler step per end-of-count of timer 0.
- R10: A pulse on `stop[i]` halts timer i, and its count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_in | input | 1 | External timing input (asynchronous; synchronised inside) |
| init_we | input | 2 | Per-timer write strobe for the holding registers |
| init_data | input | 8 | Initial count written by `init_we` |
| pre_data | input | 6 | Prescale value written by `init_we` |
| load | input | 2 | Per-timer pulse: copy the held values and start |
| stop | input | 2 | Per-timer pulse: halt |
| modulo | input | 2 | Per timer: 1 = modulo-N, 0 = single pass |
| t0_ext_src | input | 1 | Timer 0 source: 1 = external pin, 0 = time base |
| ext_fn | input | 2 | Pin role: 00 clock, 01 gate, 10 trigger |
| t1_cascade | input | 1 | Timer 1 steps on timer 0 end-of-count |
| count0 | output | 8 | Live count of timer 0 |
| count1 | output | 8 | Live count of timer 1 |
| irq | output | 2 | One-cycle end-of-count request per timer |
| tout | output | 2 | Toggling output per timer |

## Verification
Repeat periods are measured between consecutive interrupts for several prescale and count pairs. The pairs include the zero encodings, so a prescaler or counter that is off by one, or that treats 0 as empty, gives a different period. Each pin role is driven with a pattern that only that role would follow. Slow pin edges count one for one in clock mode. A held level freezes or advances the count in gate mode. A second edge in the middle of a run moves the interrupt time only if trigger mode wrongly restarts. The cascaded period shows that timer 1 steps on timer 0's end-of-count and not on the time base.

// File: rtl/timer_pkg.sv
// Package: types shared by the timer pair.
// Assumes: the external-pin role field is two bits wide.
package timer_pkg;
    typedef enum logic [1:0] {
        PIN_CLOCK = 2'b00,
        PIN_GATE  = 2'b01,
        PIN_TRIG  = 2'b10,
        PIN_RSVD  = 2'b11
    } pin_role_e;
endpackage

// File: rtl/timer_timebase.sv
// Module: timer_timebase
// Produces the internal step (system clock divided by DIV). It also
// synchronises the external pin and reports its level and rising edge.
// Assumes: ext_in is asynchronous to clk; DIV >= 2.
module timer_timebase #(
    parameter int DIV = 4,
    localparam int DW = $clog2(DIV)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic tick,
    output logic pin_level,
    output logic pin_rise
);
    logic [DW-1:0] div_q;
    logic [2:0]    sync_q;

    // Free-running divider for the internal time base.
    always_ff @(posedge clk) begin
        if (!rst_n)                        div_q <= '0;
        else if (div_q == DW'(DIV - 1))    div_q <= '0;
        else                               div_q <= div_q + 1'b1;
    end

    // Two-stage synchroniser plus one stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], ext_in};
    end

    assign tick      = (div_q == DW'(DIV - 1));
    assign pin_level = sync_q[1];
    assign pin_rise  = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/timer_prescaler.sv
// Module: timer_prescaler
// Down-counting prescaler. It gives one carry for every reload_val
// enabled steps, where 0 stands for 2**PW.
// Assumes: load has priority over step_en.
module timer_prescaler #(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step_en,
    input  logic [PW-1:0] reload_val,
    output logic          carry
);
    logic [PW-1:0] pre_q;

    // Count down, and reload on carry or on an explicit load.
    always_ff @(posedge clk) begin
        if (!rst_n)            pre_q <= '0;
        else if (load)         pre_q <= reload_val;
        else if (carry)        pre_q <= reload_val;
        else if (step_en)      pre_q <= pre_q - 1'b1;
    end

    assign carry = step_en && !load && (pre_q == PW'(1));
endmodule

// File: rtl/timer_channel.sv
// Module: timer_channel
// One timer: the prescaler, the main down counter, the run and wait
// state, the end-of-count pulse and the toggle output.
// Assumes: step is a single-cycle strobe; trig_edge is already synchronised.
module timer_channel #(
    parameter int CW = 8,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          stop,
    input  logic          modulo,
    input  logic          trig_mode,
    input  logic          step,
    input  logic          trig_edge,
    input  logic [CW-1:0] init_val,
    input  logic [PW-1:0] pre_val,
    output logic [CW-1:0] count,
    output logic          eoc,
    output logic          tout
);
    logic          run_q, wait_q, eoc_q, tout_q;
    logic [CW-1:0] cnt_q;
    logic          pre_carry;
    logic          active;

    assign active = run_q && !wait_q && !stop;

    timer_prescaler #(.PW(PW)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step_en    (active && step),
        .reload_val (pre_val),
        .carry      (pre_carry)
    );

    // Run and wait control, main counter, end-of-count and toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            wait_q <= 1'b0;
            cnt_q  <= '0;
            eoc_q  <= 1'b0;
            tout_q <= 1'b0;
        end else begin
            eoc_q <= 1'b0;
            if (load) begin
                run_q  <= 1'b1;
                wait_q <= trig_mode;
                cnt_q  <= init_val;
            end else if (stop) begin
                run_q  <= 1'b0;
                wait_q <= 1'b0;
            end else if (run_q && wait_q) begin
                if (trig_edge) wait_q <= 1'b0;
            end else if (pre_carry) begin
                if (cnt_q == CW'(1)) begin
                    eoc_q  <= 1'b1;
                    tout_q <= ~tout_q;
                    if (modulo) begin
                        cnt_q  <= init_val;
                        wait_q <= trig_mode;
                    end else begin
                        cnt_q <= '0;
                        run_q <= 1'b0;
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign count = cnt_q;
    assign eoc   = eoc_q;
    assign tout  = tout_q;

    // R5: the request lasts a single cycle.
    assert_irq_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_q |=> !eoc_q);
    // R5: the output changes exactly when a request is raised.
    assert_tout_follows_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tout_q != $past(tout_q)) == eoc_q);
    // R10: an idle timer keeps its count until a load.
    assert_halt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !load) |=> $stable(cnt_q));
    // R8: a timer armed for a trigger does not count.
    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && wait_q && !load) |=> $stable(cnt_q));
    // R3: a single-pass end leaves the timer stopped at zero.
    assert_single_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_carry && cnt_q == CW'(1) && !modulo && !load && !stop) |=> (!run_q && cnt_q == '0));
endmodule

// File: rtl/prescaled_timer_pair.sv
// Module: prescaled_timer_pair
// Two prescaled down-counter timers. Timer 0 has a source select that
// covers the pin roles; timer 1 can be cascaded from timer 0.
// Assumes: control inputs are synchronous to clk; ext_in may be asynchronous.
module prescaled_timer_pair #(
    parameter int CW     = 8,
    parameter int PW     = 6,
    parameter int DIV    = 4,
    parameter int NTIMER = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_in,
    input  logic [NTIMER-1:0] init_we,
    input  logic [CW-1:0]     init_data,
    input  logic [PW-1:0]     pre_data,
    input  logic [NTIMER-1:0] load,
    input  logic [NTIMER-1:0] stop,
    input  logic [NTIMER-1:0] modulo,
    input  logic              t0_ext_src,
    input  logic [1:0]        ext_fn,
    input  logic              t1_cascade,
    output logic [CW-1:0]     count0,
    output logic [CW-1:0]     count1,
    output logic [NTIMER-1:0] irq,
    output logic [NTIMER-1:0] tout
);
    import timer_pkg::*;

    logic              tick, pin_level, pin_rise;
    logic [NTIMER-1:0] step, trig_mode;
    logic [CW-1:0]     init_q  [NTIMER];
    logic [PW-1:0]     pre_q   [NTIMER];
    logic [CW-1:0]     cnt_w   [NTIMER];
    pin_role_e         role;

    assign role = pin_role_e'(ext_fn);

    timer_timebase #(.DIV(DIV)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_in    (ext_in),
        .tick      (tick),
        .pin_level (pin_level),
        .pin_rise  (pin_rise)
    );

    // Timer 0 step source: the time base, or the pin in its chosen role.
    always_comb begin
        step[0]      = tick;
        trig_mode[0] = 1'b0;
        if (t0_ext_src) begin
            case (role)
                PIN_GATE: step[0] = tick & pin_level;
                PIN_TRIG: begin
                    step[0]      = tick;
                    trig_mode[0] = 1'b1;
                end
                default:  step[0] = pin_rise;
            endcase
        end
    end

    // Timer 1 step source: the time base or timer 0 end-of-count.
    always_comb begin
        step[1]      = t1_cascade ? irq[0] : tick;
        trig_mode[1] = 1'b0;
    end

    for (genvar i = 0; i < NTIMER; i++) begin : g_tmr
        // Holding registers for the initial count and prescale value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                init_q[i] <= '0;
                pre_q[i]  <= '0;
            end else if (init_we[i]) begin
                init_q[i] <= init_data;
                pre_q[i]  <= pre_data;
            end
        end

        timer_channel #(.CW(CW), .PW(PW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load[i]),
            .stop      (stop[i]),
            .modulo    (modulo[i]),
            .trig_mode (trig_mode[i]),
            .step      (step[i]),
            .trig_edge (pin_rise),
            .init_val  (init_q[i]),
            .pre_val   (pre_q[i]),
            .count     (cnt_w[i]),
            .eoc       (irq[i]),
            .tout      (tout[i])
        );
    end

    assign count0 = cnt_w[0];
    assign count1 = cnt_w[1];
endmodule

// File: tb/prescaled_timer_pair_bench.sv
module prescaled_timer_pair_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_in = 1'b0;
    logic [1:0] init_we = '0;
    logic [7:0] init_data = '0;
    logic [5:0] pre_data = '0;
    logic [1:0] load = '0;
    logic [1:0] stop = '0;
    logic [1:0] modulo = '0;
    logic       t0_ext_src = 1'b0;
    logic [1:0] ext_fn = '0;
    logic       t1_cascade = 1'b0;
    logic [7:0] count0, count1;
    logic [1:0] irq, tout;

    int n_chk = 0;
    int n_bad = 0;
    int irq_seen [2] = '{0, 0};
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prescaled_timer_pair u_prescaled_timer_pair (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .init_we(init_we),
        .init_data(init_data), .pre_data(pre_data), .load(load), .stop(stop),
        .modulo(modulo), .t0_ext_src(t0_ext_src), .ext_fn(ext_fn),
        .t1_cascade(t1_cascade), .count0(count0), .count1(count1),
        .irq(irq), .tout(tout)
    );

    always @(negedge clk) begin
        if (irq[0]) irq_seen[0]++;
        if (irq[1]) irq_seen[1]++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input int t, input int n, input int p, input bit md);
        @(negedge clk);
        init_data = 8'(n); pre_data = 6'(p); init_we[t] = 1'b1; modulo[t] = md;
        @(negedge clk);
        init_we = '0;
    endtask

    task automatic start(input int t);
        load[t] = 1'b1;
        @(negedge clk);
        load = '0;
    endtask

    task automatic halt_all();
        stop = 2'b11;
        @(negedge clk);
        stop = '0;
        t0_ext_src = 1'b0; t1_cascade = 1'b0; ext_fn = 2'b00; ext_in = 1'b0;
        cycles(8);
    endtask

    task automatic wait_irq(input int t, input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq[t] && n < lim);
    endtask

    task automatic t_reset();
        chk("R1 count0", count0, 0);
        chk("R1 count1", count1, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tout", tout, 0);
        cycles(40);
        chk("R1 idle irqs", irq_seen[0] + irq_seen[1], 0);
    endtask

    task automatic t_period(input int t, input int n, input int p, input int exp);
        int d;
        setup(t, n, p, 1'b1);
        start(t);
        wait_irq(t, exp + 20, d);
        wait_irq(t, exp + 20, d);
        chk($sformatf("R2 period t%0d n%0d p%0d", t, n, p), d, exp);
        halt_all();
    endtask

    task automatic t_load_and_toggle();
        int d;
        logic tv;
        setup(0, 200, 1, 1'b1);
        start(0);
        chk("R4 load value", count0, 200);
        cycles(20);
        stop[0] = 1'b1; @(negedge clk); stop = '0;
        d = count0;
        cycles(30);
        chk("R10 stopped count holds", count0, d);
        setup(0, 55, 1, 1'b1);
        chk("R4 write alone keeps count", count0, d);
        start(0);
        chk("R4 reload on load", count0, 55);
        halt_all();
        setup(0, 2, 1, 1'b1);
        start(0);
        tv = tout[0];
        wait_irq(0, 40, d);
        chk("R5 tout toggles at irq", tout[0], int'(!tv));
        @(negedge clk);
        chk("R5 irq one cycle", irq[0], 0);
        halt_all();
    endtask

    task automatic t_single();
        int base;
        base = irq_seen[1];
        setup(1, 3, 2, 1'b0);
        start(1);
        cycles(60);
        chk("R3 one pulse", irq_seen[1] - base, 1);
        chk("R3 count zero", count1, 0);
        cycles(40);
        chk("R3 still zero, no pulse", count1 + irq_seen[1] - base, 1);
        halt_all();
    endtask

    task automatic t_ext_clock();
        int base;
        t0_ext_src = 1'b1; ext_fn = 2'b00;
        setup(0, 3, 1, 1'b1);
        start(0);
        base = irq_seen[0];
        cycles(20);
        chk("R6 no edge no count", count0, 3);
        ext_in = 1'b1; cycles(4); ext_in = 1'b0; cycles(4);
        chk("R6 one edge one step", count0, 2);
        for (int k = 0; k < 2; k++) begin
            ext_in = 1'b1; cycles(4); ext_in = 1'b0; cycles(4);
        end
        chk("R6 third edge ends count", irq_seen[0] - base, 1);
        chk("R6 reloaded", count0, 3);
        halt_all();
    endtask

    task automatic t_gate();
        int a;
        t0_ext_src = 1'b1; ext_fn = 2'b01;
        setup(0, 100, 1, 1'b1);
        start(0);
        cycles(40);
        chk("R7 gate low frozen", count0, 100);
        ext_in = 1'b1;
        cycles(40);
        chk_range("R7 gate high counts", count0, 88, 92);
        ext_in = 1'b0;
        cycles(5);
        a = count0;
        cycles(40);
        chk("R7 frozen again", count0, a);
        halt_all();
    endtask

    task automatic t_trigger();
        int d, base;
        t0_ext_src = 1'b1; ext_fn = 2'b10;
        setup(0, 8, 1, 1'b1);
        start(0);
        cycles(30);
        chk("R8 waits for edge", count0, 8);
        base = irq_seen[0];
        d = 0;
        ext_in = 1'b1; cycles(4); ext_in = 1'b0; d = 4;
        cycles(12); d += 12;
        ext_in = 1'b1; cycles(4); ext_in = 1'b0; d += 4;
        while (!irq[0] && d < 80) begin @(negedge clk); d++; end
        chk_range("R8 mid-run edge ignored", d, 31, 40);
        cycles(40);
        chk("R8 rearmed and waiting", count0, 8);
        chk("R8 single pulse", irq_seen[0] - base, 1);
        halt_all();
    endtask

    task automatic t_cascade();
        int d;
        setup(0, 2, 1, 1'b1);
        setup(1, 3, 1, 1'b1);
        t1_cascade = 1'b1;
        start(0);
        start(1);
        wait_irq(1, 100, d);
        wait_irq(1, 100, d);
        chk("R9 cascaded period", d, 24);
        halt_all();
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period(0, 5, 3, 60);
        t_period(1, 1, 0, 256);
        t_period(0, 0, 1, 1024);
        t_load_and_toggle();
        t_single();
        t_ext_clock();
        t_gate();
        t_trigger();
        t_cascade();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule